// File: doc/BRIEF.md
# Variable-Step Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor whose stack grows toward lower addresses in data SRAM. Four strobes move it: a one-byte data push, a one-byte data pop, a two-byte push of a return address (used for calls and interrupt entry), and a two-byte pop of a return address (used for both kinds of return). For every accepted strobe the block drives, in the same cycle, the SRAM address or addresses of the stack bytes to access, together with write, read and pair qualifiers. The pointer register then moves on the next clock edge.

Software loads the pointer through two byte-wide write strobes, one for each half, and reads both halves at any time. The stack must sit above a floor address, 0x60 by default, because lower locations are not usable as stack space. A flag reports whenever the pointer is at or below that floor, for example after reset when software has not yet set it up. Stack strobes that collide in one cycle are dropped and reported with a single-cycle error pulse.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0000, the collision pulse is low and no memory access is requested.
- R2: An accepted one-byte push asserts the write qualifier with the address equal to the current pointer, and the pointer is one lower after the clock edge.
- R3: An accepted two-byte push asserts write and pair, puts the low-order byte at the current pointer (first address output) and the high-order byte at pointer minus one (second address output), and the pointer is two lower after the edge.
- R4: An accepted one-byte pop asserts the read qualifier with the address equal to pointer plus one, and the pointer is one higher after the edge.
- R5: An accepted two-byte pop asserts read and pair, reads the low-order byte at pointer plus two (first address output) and the high-order byte at pointer plus one (second address output), and the pointer is two higher after the edge.
- R6: A low-half write loads the write data into pointer bits 7:0, a high-half write loads it into bits 15:8, both on the next edge; the two halves are always readable on their own outputs.
- R7: A software write in the same cycle as a stack strobe wins: the strobe neither moves the pointer nor requests a memory access.
- R8: The floor flag is high exactly while the pointer is less than or equal to 0x60.
- R9: When two or more stack strobes arrive in one cycle, all are ignored (no pointer change, no memory access) and the collision output is high for exactly the following cycle.
- R10: Pointer arithmetic wraps modulo 2^16 (0x0001 minus two gives 0xFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_byte_i | input | 1 | One-byte data push strobe |
| pop_byte_i | input | 1 | One-byte data pop strobe |
| push_ret_i | input | 1 | Two-byte return-address push strobe |
| pop_ret_i | input | 1 | Two-byte return-address pop strobe |
| sw_wr_lo_i | input | 1 | Software write to pointer bits 7:0 |
| sw_wr_hi_i | input | 1 | Software write to pointer bits 15:8 |
| sw_wdata_i | input | 8 | Software write data |
| sp_lo_o | output | 8 | Pointer bits 7:0 |
| sp_hi_o | output | 8 | Pointer bits 15:8 |
| mem_addr_o | output | 16 | Address of the single byte, or of the low-order byte of a pair |
| mem_addr2_o | output | 16 | Address of the high-order byte of a pair |
| mem_wr_o | output | 1 | Stack write requested this cycle |
| mem_rd_o | output | 1 | Stack read requested this cycle |
| mem_pair_o | output | 1 | The access covers two bytes |
| below_floor_o | output | 1 | Pointer is at or below the floor address |
| conflict_o | output | 1 | Collision pulse, one cycle after colliding strobes |

## Verification
The bench targets the asymmetric address rule: a design that reads a pop at the old pointer instead of the new one, or swaps the byte order of a return address, returns corrupt data, so every access address is compared in the cycle it is presented. The floor is probed at 0x61, 0x60 and back, where an off-by-one comparison flips the flag one step early or late. Colliding strobes, with and without a simultaneous software write, catch a design that lets one strobe through or stretches the pulse, and a push of a return address from 0x0001 exposes missing wrap-around.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Decoded stack operation for one cycle
  typedef enum logic [2:0] {
    SOP_IDLE   = 3'd0,
    SOP_PUSH_B = 3'd1,
    SOP_PUSH_R = 3'd2,
    SOP_POP_B  = 3'd3,
    SOP_POP_R  = 3'd4
  } sop_e;

  // Signed pointer movement caused by an operation
  function automatic int op_step(input sop_e op);
    case (op)
      SOP_PUSH_B: return -1;
      SOP_PUSH_R: return -2;
      SOP_POP_B:  return 1;
      SOP_POP_R:  return 2;
      default:    return 0;
    endcase
  endfunction

  // Offset from the current pointer of the single byte / low-order byte
  function automatic int first_offset(input sop_e op);
    case (op)
      SOP_POP_B: return 1;
      SOP_POP_R: return 2;
      default:   return 0;
    endcase
  endfunction

  // Offset from the current pointer of the high-order byte of a pair
  function automatic int second_offset(input sop_e op);
    case (op)
      SOP_PUSH_R: return -1;
      SOP_POP_R:  return 1;
      default:    return first_offset(op);
    endcase
  endfunction

  function automatic logic is_push(input sop_e op);
    return (op == SOP_PUSH_B) || (op == SOP_PUSH_R);
  endfunction

  function automatic logic is_pop(input sop_e op);
    return (op == SOP_POP_B) || (op == SOP_POP_R);
  endfunction

  function automatic logic is_pair(input sop_e op);
    return (op == SOP_PUSH_R) || (op == SOP_POP_R);
  endfunction

endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import sp_pkg::*;
(
  input  logic push_byte,
  input  logic pop_byte,
  input  logic push_ret,
  input  logic pop_ret,
  input  logic sw_busy,
  output sop_e op,
  output logic accept,
  output logic conflict
);
  localparam int NSTROBE = 4;

  logic [NSTROBE-1:0] strobes;
  logic               single;

  assign strobes  = {push_byte, pop_byte, push_ret, pop_ret};
  assign single   = ($countones(strobes) == 1);
  assign conflict = ($countones(strobes) > 1);
  // A software write blocks any stack movement in its cycle
  assign accept   = single && !sw_busy;

  always_comb begin
    op = SOP_IDLE;
    if (accept) begin
      if (push_byte)     op = SOP_PUSH_B;
      else if (push_ret) op = SOP_PUSH_R;
      else if (pop_byte) op = SOP_POP_B;
      else               op = SOP_POP_R;
    end
  end
endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
  import sp_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RESET_VAL = '0,
  localparam int         HW        = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  input  logic          accept,
  input  sop_e          op,
  output logic [AW-1:0] sp_q
);
  logic [AW-1:0] sp_d;

  always_comb begin
    sp_d = sp_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) sp_d[HW-1:0]  = wdata;
      if (wr_hi) sp_d[AW-1:HW] = wdata;
    end else if (accept) begin
      sp_d = sp_q + AW'(op_step(op));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= RESET_VAL;
    else        sp_q <= sp_d;
  end
endmodule

// File: rtl/sp_access_gen.sv
module sp_access_gen
  import sp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] sp,
  input  sop_e          op,
  input  logic          accept,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr2,
  output logic          wr,
  output logic          rd,
  output logic          pair
);
  assign addr  = sp + AW'(first_offset(op));
  assign addr2 = sp + AW'(second_offset(op));
  assign wr    = accept && is_push(op);
  assign rd    = accept && is_pop(op);
  assign pair  = accept && is_pair(op);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] FLOOR     = 16'h0060,
  parameter logic [AW-1:0] RESET_VAL = '0,
  localparam int           HW        = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_byte_i,
  input  logic          pop_byte_i,
  input  logic          push_ret_i,
  input  logic          pop_ret_i,
  input  logic          sw_wr_lo_i,
  input  logic          sw_wr_hi_i,
  input  logic [HW-1:0] sw_wdata_i,
  output logic [HW-1:0] sp_lo_o,
  output logic [HW-1:0] sp_hi_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_addr2_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic          mem_pair_o,
  output logic          below_floor_o,
  output logic          conflict_o
);
  // Named internal events, visible to the bound checker
  sop_e          op_now;
  logic          op_accept;
  logic          conflict_now;
  logic          sw_busy;
  logic [AW-1:0] sp_q;
  logic          conflict_q;

  assign sw_busy = sw_wr_lo_i || sw_wr_hi_i;

  sp_op_decode u_dec (
    .push_byte (push_byte_i),
    .pop_byte  (pop_byte_i),
    .push_ret  (push_ret_i),
    .pop_ret   (pop_ret_i),
    .sw_busy   (sw_busy),
    .op        (op_now),
    .accept    (op_accept),
    .conflict  (conflict_now)
  );

  sp_ptr_reg #(.AW(AW), .RESET_VAL(RESET_VAL)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (sw_wr_lo_i),
    .wr_hi  (sw_wr_hi_i),
    .wdata  (sw_wdata_i),
    .accept (op_accept),
    .op     (op_now),
    .sp_q   (sp_q)
  );

  sp_access_gen #(.AW(AW)) u_acc (
    .sp     (sp_q),
    .op     (op_now),
    .accept (op_accept),
    .addr   (mem_addr_o),
    .addr2  (mem_addr2_o),
    .wr     (mem_wr_o),
    .rd     (mem_rd_o),
    .pair   (mem_pair_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict_q <= 1'b0;
    else        conflict_q <= conflict_now;
  end

  assign conflict_o    = conflict_q;
  assign below_floor_o = (sp_q <= FLOOR);
  assign sp_lo_o       = sp_q[HW-1:0];
  assign sp_hi_o       = sp_q[AW-1:HW];
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int            AW    = 16,
  parameter logic [AW-1:0] FLOOR = 16'h0060,
  localparam int           HW    = AW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_byte_i,
  input logic          pop_byte_i,
  input logic          push_ret_i,
  input logic          pop_ret_i,
  input logic          sw_wr_lo_i,
  input logic          sw_wr_hi_i,
  input logic [HW-1:0] sw_wdata_i,
  input logic [HW-1:0] sp_lo_o,
  input logic [HW-1:0] sp_hi_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_wr_o,
  input logic          mem_rd_o,
  input logic          below_floor_o,
  input logic          conflict_o,
  input logic          op_accept,
  input logic          conflict_now
);
  logic [AW-1:0] sp_seen;
  logic          quiet;
  assign sp_seen = {sp_hi_o, sp_lo_o};
  assign quiet   = !sw_wr_lo_i && !sw_wr_hi_i;

  assert_push_byte_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_byte_i && !pop_byte_i && !push_ret_i && !pop_ret_i && quiet)
      |=> sp_seen == $past(sp_seen) - AW'(1));

  assert_push_ret_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret_i && !pop_byte_i && !push_byte_i && !pop_ret_i && quiet)
      |=> sp_seen == $past(sp_seen) - AW'(2));

  assert_pop_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_byte_i && !push_byte_i && !push_ret_i && !pop_ret_i && quiet)
      |=> sp_seen == $past(sp_seen) + AW'(1));

  assert_pop_ret_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ret_i && !pop_byte_i && !push_ret_i && !push_byte_i && quiet)
      |=> sp_seen == $past(sp_seen) + AW'(2));

  assert_push_at_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> mem_addr_o == sp_seen);

  assert_sw_low_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_lo_i |=> sp_lo_o == $past(sw_wdata_i));

  assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |-> !mem_wr_o && !mem_rd_o);

  assert_floor_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    below_floor_o == (sp_seen <= FLOOR));

  assert_conflict_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_now && quiet) |=> conflict_o && $stable(sp_seen));

  assert_conflict_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict_now |=> !conflict_o);

  assert_conflict_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_now |-> !op_accept);

  assert_access_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o));
endmodule

bind stack_ptr_unit sp_checker #(.AW(AW), .FLOOR(FLOOR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .push_byte_i   (push_byte_i),
  .pop_byte_i    (pop_byte_i),
  .push_ret_i    (push_ret_i),
  .pop_ret_i     (pop_ret_i),
  .sw_wr_lo_i    (sw_wr_lo_i),
  .sw_wr_hi_i    (sw_wr_hi_i),
  .sw_wdata_i    (sw_wdata_i),
  .sp_lo_o       (sp_lo_o),
  .sp_hi_o       (sp_hi_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wr_o      (mem_wr_o),
  .mem_rd_o      (mem_rd_o),
  .below_floor_o (below_floor_o),
  .conflict_o    (conflict_o),
  .op_accept     (op_accept),
  .conflict_now  (conflict_now)
);

// File: tb/stack_ptr_unit_test.sv
`timescale 1ns/1ps
module stack_ptr_unit_test;
  localparam int AW = 16;
  localparam int HW = 8;
  localparam logic [AW-1:0] FLOOR = 16'h0060;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_byte_i = 0, pop_byte_i = 0, push_ret_i = 0, pop_ret_i = 0;
  logic sw_wr_lo_i = 0, sw_wr_hi_i = 0;
  logic [HW-1:0] sw_wdata_i = '0;
  logic [HW-1:0] sp_lo_o, sp_hi_o;
  logic [AW-1:0] mem_addr_o, mem_addr2_o;
  logic mem_wr_o, mem_rd_o, mem_pair_o, below_floor_o, conflict_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stack_ptr_unit uut (.*);

  // Vector: {wl, wh, wdata[8], strobes{push_b,pop_b,push_r,pop_r}[4],
  //          exp_sp[16], {wr,rd,pair,conflict}[4], exp_addr[16], exp_addr2[16]}
  localparam int VW = 66;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b01, 8'h01, 4'b0000, 16'h0100, 4'b0000, 16'h0000, 16'h0000}, // R6 high load
    {2'b10, 8'h80, 4'b0000, 16'h0180, 4'b0000, 16'h0000, 16'h0000}, // R6 low load
    {2'b00, 8'h00, 4'b1000, 16'h017F, 4'b1000, 16'h0180, 16'h0000}, // R2
    {2'b00, 8'h00, 4'b0010, 16'h017D, 4'b1010, 16'h017F, 16'h017E}, // R3
    {2'b00, 8'h00, 4'b0100, 16'h017E, 4'b0100, 16'h017E, 16'h0000}, // R4
    {2'b00, 8'h00, 4'b0001, 16'h0180, 4'b0110, 16'h0180, 16'h017F}, // R5
    {2'b00, 8'h00, 4'b1100, 16'h0180, 4'b0001, 16'h0000, 16'h0000}, // R9
    {2'b00, 8'h00, 4'b0011, 16'h0180, 4'b0001, 16'h0000, 16'h0000}, // R9
    {2'b10, 8'h10, 4'b1000, 16'h0110, 4'b0000, 16'h0000, 16'h0000}, // R7
    {2'b01, 8'h00, 4'b0001, 16'h0010, 4'b0000, 16'h0000, 16'h0000}, // R7
    {2'b00, 8'h00, 4'b1010, 16'h0010, 4'b0001, 16'h0000, 16'h0000}, // R9
    {2'b00, 8'h00, 4'b0010, 16'h000E, 4'b1010, 16'h0010, 16'h000F}  // R3
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %h, expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wl, input logic wh, input logic [HW-1:0] wd,
                       input logic [3:0] st);
    @(negedge clk);
    sw_wr_lo_i = wl; sw_wr_hi_i = wh; sw_wdata_i = wd;
    {push_byte_i, pop_byte_i, push_ret_i, pop_ret_i} = st;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, 4'b0000);
  endtask

  function automatic logic [AW-1:0] sp_now();
    return {sp_hi_o, sp_lo_o};
  endfunction

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sp_now() == 16'h0000, "R1", "pointer after reset", sp_now(), 16'h0000);
    check(conflict_o == 1'b0, "R1", "collision after reset", AW'(conflict_o), 16'h0);
    check(!mem_wr_o && !mem_rd_o, "R1", "access after reset", AW'({mem_wr_o, mem_rd_o}), 16'h0);
    check(below_floor_o == 1'b1, "R8", "floor flag at 0x0000", AW'(below_floor_o), 16'h1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[65], v[64], v[63:56], v[55:52]);
      #1;
      check(mem_wr_o == v[35], "R2/R3", "write qualifier", AW'(mem_wr_o), AW'(v[35]));
      check(mem_rd_o == v[34], "R4/R5", "read qualifier", AW'(mem_rd_o), AW'(v[34]));
      check(mem_pair_o == v[33], "R3/R5", "pair qualifier", AW'(mem_pair_o), AW'(v[33]));
      if (v[35] || v[34])
        check(mem_addr_o == v[31:16], "R2..R5 first", "address", mem_addr_o, v[31:16]);
      if (v[33])
        check(mem_addr2_o == v[15:0], "R3/R5 second", "address", mem_addr2_o, v[15:0]);
      after_edge();
      check(sp_now() == v[51:36], "R2..R7", "pointer", sp_now(), v[51:36]);
      check(conflict_o == v[32], "R9", "collision pulse", AW'(conflict_o), AW'(v[32]));
      check(below_floor_o == (v[51:36] <= FLOOR), "R8", "floor flag",
            AW'(below_floor_o), AW'(v[51:36] <= FLOOR));
    end

    // R9: collision pulse lasts exactly one cycle
    idle();
    after_edge();
    check(conflict_o == 1'b0, "R9", "pulse width", AW'(conflict_o), 16'h0);

    // R8: floor boundary at 0x61 / 0x60 / 0x61
    drive(1'b1, 1'b1, 8'h00, 4'b0000);
    drive(1'b1, 1'b0, 8'h61, 4'b0000);
    after_edge();
    check(below_floor_o == 1'b0, "R8", "flag at 0x0061", AW'(below_floor_o), 16'h0);
    drive(1'b0, 1'b0, 8'h00, 4'b1000);
    after_edge();
    check(sp_now() == 16'h0060, "R2", "pointer at floor", sp_now(), 16'h0060);
    check(below_floor_o == 1'b1, "R8", "flag at 0x0060", AW'(below_floor_o), 16'h1);
    drive(1'b0, 1'b0, 8'h00, 4'b0100);
    after_edge();
    check(below_floor_o == 1'b0, "R8", "flag back at 0x0061", AW'(below_floor_o), 16'h0);

    // R10: wrap below zero and back
    drive(1'b1, 1'b0, 8'h01, 4'b0000);
    drive(1'b0, 1'b0, 8'h00, 4'b0010);
    #1;
    check(mem_addr2_o == 16'h0000, "R10", "second address at wrap", mem_addr2_o, 16'h0000);
    after_edge();
    check(sp_now() == 16'hFFFF, "R10", "pointer after wrap", sp_now(), 16'hFFFF);
    check(sp_hi_o == 8'hFF, "R6", "high half read", AW'(sp_hi_o), 16'h00FF);
    drive(1'b0, 1'b0, 8'h00, 4'b0001);
    #1;
    check(mem_addr_o == 16'h0001, "R10", "pop address across wrap", mem_addr_o, 16'h0001);
    after_edge();
    check(sp_now() == 16'h0001, "R10", "pointer after wrap back", sp_now(), 16'h0001);

    // R9 with software write: write still lands, strobes dropped
    drive(1'b0, 1'b1, 8'h02, 4'b1001);
    after_edge();
    check(sp_now() == 16'h0201, "R7", "write during collision", sp_now(), 16'h0201);
    check(conflict_o == 1'b1, "R9", "pulse with software write", AW'(conflict_o), 16'h1);

    // R1: reset in mid-run
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sp_now() == 16'h0000, "R1", "pointer after mid-run reset", sp_now(), 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule